// File: doc/BRIEF.md
# Unicast exact-match address filter

This block keeps a small table of 48-bit station addresses and decides, for every destination address presented to it, whether the address belongs to one of the enabled table entries. A hit reports the lowest matching entry number and the pool-membership bitmap kept with that entry. The receive path uses the result to accept the frame and to learn which pools it belongs to.

Software reaches the table indirectly. It first writes an entry number into a selector register, and later accesses to the address-low, address-high and pool registers act on that entry. Each entry has an enable bit in its high word next to a spare tag field, and a pool bitmap that grows with pool-set writes and shrinks with pool-clear writes. When a pool clear empties the bitmap of any entry other than entry 0, that entry's address and enable bit are wiped in the same cycle. Entry 0 holds the station's own address from reset.

Top module: `ucast_addr_filter`

## Requirements
- R1: Writing offset 0 loads the entry selector from `reg_wdata[7:0]`. Reads of offset 0 return it, and writes and reads at offsets 1 to 4 act only on the selected entry.
- R2: Offset 1 (low word) holds address byte 5 in bits [7:0], byte 4 in [15:8], byte 3 in [23:16] and byte 2 in [31:24]. Offset 2 (high word) holds byte 1 in [7:0], byte 0 in [15:8], a 15-bit tag in [30:16] and the enable bit in [31]. Byte 0 is the first byte of the address on the wire and is `lk_da[47:40]`. Reads return the stored fields in the same positions.
- R3: Only entries whose enable bit is 1 can match a looked-up address.
- R4: Address-word writes update only the byte lanes whose `reg_be` bit is 1. A high-word write with lanes 2 and 3 off leaves the tag and the enable bit unchanged.
- R5: Writing offset 3 sets pool bit `reg_wdata[4:0]` of the selected entry, and writing offset 4 clears that bit. Other pool bits are kept, and reads of either offset return the bitmap.
- R6: If a pool clear leaves the bitmap at zero and the selected entry is not entry 0, the entry's address and enable bit become zero while its tag is kept. Entry 0 is never cleared this way.
- R7: With a selector value of 32 or more, writes to offsets 1 to 4 change no entry, and reads of offsets 1 to 4 return zero.
- R8: After reset, entry 0 holds `STATION_ADDR` with its enable bit set. All other entries, every tag and every pool bitmap are zero, and the selector is 0.
- R9: One cycle after `lk_vld`, `res_vld` is 1. `res_hit` then reports a match, `res_idx` the lowest matching entry and `res_pool` that entry's bitmap. On a miss, `res_idx` and `res_pool` are zero.
- R10: A read strobe returns `reg_rdata` with `reg_rd_vld` high exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_ofs | input | 3 | Register offset (0 selector, 1 low, 2 high, 3 pool set, 4 pool clear) |
| reg_be | input | 4 | Byte-lane enables for address-word writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rd_vld |
| reg_rd_vld | output | 1 | Read data valid |
| lk_vld | input | 1 | Lookup strobe |
| lk_da | input | 48 | Destination address to look up, byte 0 in [47:40] |
| res_vld | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address matched an enabled entry |
| res_idx | output | 5 | Lowest matching entry |
| res_pool | output | 32 | Pool bitmap of the matching entry |

## Verification
A corrupted entry shows up as a wrong or missing hit on the first lookup of that address. It also shows up as a wrong read-back value one cycle after the read strobe. Every lookup result is compared, as it arrives, against a table kept by the bench. As a result, a stale enable bit, a lane written by mistake or a missed auto-clear appears one cycle after the next lookup or read that touches the entry. Lookups with overlapping entries and with out-of-range selectors show whether the priority and the write masking are right.

// File: rtl/ucf_pkg.sv
package ucf_pkg;

   localparam int ADDR_W = 48;
   localparam int DATA_W = 32;
   localparam int TAG_W  = 15;

   typedef enum logic [2:0] {
      REG_INDEX    = 3'd0,
      REG_LO       = 3'd1,
      REG_HI       = 3'd2,
      REG_POOL_SET = 3'd3,
      REG_POOL_CLR = 3'd4
   } ucf_reg_e;

   typedef struct packed {
      logic              valid;
      logic [TAG_W-1:0]  tag;
      logic [ADDR_W-1:0] mac;
   } ucf_ent_t;

endpackage

// File: rtl/ucf_regif.sv
module ucf_regif
   import ucf_pkg::*;
#(
   parameter int ENTRIES   = 32,
   parameter int POOLS     = 32,
   parameter int IDX_REG_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic                          reg_rd,
   input  logic [2:0]                    reg_ofs,
   input  logic [IDX_REG_W-1:0]          idx_wdata,
   output logic [DATA_W-1:0]             reg_rdata,
   output logic                          reg_rd_vld,
   input  ucf_ent_t [ENTRIES-1:0]        ent_i,
   input  logic [ENTRIES-1:0][POOLS-1:0] pool_i,
   output logic [ENTRIES-1:0]            sel_o,
   output logic                          idx_ok_o,
   output logic                          wr_lo_o,
   output logic                          wr_hi_o,
   output logic                          pool_set_o,
   output logic                          pool_clr_o
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [IDX_REG_W:0] ENT_LIM = ENTRIES[IDX_REG_W:0];

   logic [IDX_REG_W-1:0] idx_q;
   logic                 idx_ok;
   ucf_ent_t             cur;
   logic [POOLS-1:0]     cur_pool;
   logic [DATA_W-1:0]    rd_next;

   assign idx_ok   = ({1'b0, idx_q} < ENT_LIM);
   assign idx_ok_o = idx_ok;
   assign cur      = ent_i[idx_q[IDX_W-1:0]];
   assign cur_pool = pool_i[idx_q[IDX_W-1:0]];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
      assign sel_o[e] = idx_ok && (idx_q == IDX_REG_W'(e));
   end

   assign wr_lo_o    = reg_wr && idx_ok && (reg_ofs == REG_LO);
   assign wr_hi_o    = reg_wr && idx_ok && (reg_ofs == REG_HI);
   assign pool_set_o = reg_wr && idx_ok && (reg_ofs == REG_POOL_SET);
   assign pool_clr_o = reg_wr && idx_ok && (reg_ofs == REG_POOL_CLR);

   always_comb begin
      rd_next = '0;
      case (reg_ofs)
         REG_INDEX:    rd_next = DATA_W'(idx_q);
         REG_LO:       if (idx_ok) rd_next = cur.mac[31:0];
         REG_HI:       if (idx_ok) rd_next = {cur.valid, cur.tag, cur.mac[47:32]};
         REG_POOL_SET,
         REG_POOL_CLR: if (idx_ok) rd_next = DATA_W'(cur_pool);
         default:      rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         reg_rdata  <= '0;
         reg_rd_vld <= 1'b0;
      end else begin
         if (reg_wr && (reg_ofs == REG_INDEX)) idx_q <= idx_wdata;
         reg_rd_vld <= reg_rd;
         reg_rdata  <= reg_rd ? rd_next : '0;
      end
   end

   p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> reg_rd_vld)
      else $error("read strobe without data valid");
   p_rd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !reg_rd_vld)
      else $error("data valid without read strobe");
   p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !idx_ok && (reg_ofs != REG_INDEX)) |=> (reg_rdata == '0))
      else $error("out-of-range read returned data");
   p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_ofs == REG_INDEX)) |=> (idx_q == $past(idx_wdata)))
      else $error("selector not loaded");

endmodule

// File: rtl/ucf_entry.sv
module ucf_entry
   import ucf_pkg::*;
#(
   parameter int                IDX     = 0,
   parameter int                POOLS   = 32,
   parameter logic [ADDR_W-1:0] RST_MAC = '0,
   parameter bit                RST_VLD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              pool_set,
   input  logic              pool_clr,
   input  logic [3:0]        be,
   input  logic [DATA_W-1:0] wdata,
   output ucf_ent_t          ent_o,
   output logic [POOLS-1:0]  pool_o
);
   localparam int PSEL_W = $clog2(POOLS);

   ucf_ent_t         ent_q;
   logic [POOLS-1:0] pool_q;
   logic [POOLS-1:0] pool_oh;
   logic [POOLS-1:0] pool_left;
   logic             drop;

   assign pool_oh   = POOLS'(1) << wdata[PSEL_W-1:0];
   assign pool_left = pool_q & ~pool_oh;

   if (IDX == 0) begin : g_keep
      assign drop = 1'b0;
      p_entry0_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && pool_clr) |=> ($stable(ent_q.mac) && $stable(ent_q.valid)))
         else $error("entry 0 auto-cleared");
   end else begin : g_drop
      assign drop = (pool_left == '0);
      p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && pool_clr && drop) |=> (!ent_q.valid && (ent_q.mac == '0)))
         else $error("emptied entry not cleared");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_q.mac   <= RST_MAC;
         ent_q.valid <= RST_VLD;
         ent_q.tag   <= '0;
         pool_q      <= '0;
      end else if (sel) begin
         if (wr_lo) begin
            for (int b = 0; b < 4; b++) begin
               if (be[b]) ent_q.mac[8*b +: 8] <= wdata[8*b +: 8];
            end
         end
         if (wr_hi) begin
            if (be[0]) ent_q.mac[39:32] <= wdata[7:0];
            if (be[1]) ent_q.mac[47:40] <= wdata[15:8];
            if (be[2]) ent_q.tag[7:0]   <= wdata[23:16];
            if (be[3]) {ent_q.valid, ent_q.tag[14:8]} <= wdata[31:24];
         end
         if (pool_set) pool_q <= pool_q | pool_oh;
         if (pool_clr) begin
            pool_q <= pool_left;
            if (drop) begin
               ent_q.mac   <= '0;
               ent_q.valid <= 1'b0;
            end
         end
      end
   end

   assign ent_o  = ent_q;
   assign pool_o = pool_q;

   p_valid_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ent_q.valid) |-> $past(sel && wr_hi && be[3]))
      else $error("enable bit set without a high-word write");
   p_lane_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && wr_hi && !be[3]) |=> ($stable(ent_q.valid) && $stable(ent_q.tag[14:8])))
      else $error("disabled lane changed");
   p_pool_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && pool_set) |=> ((pool_q & $past(pool_oh)) != '0))
      else $error("pool bit not set");

endmodule

// File: rtl/ucf_match.sv
module ucf_match
   import ucf_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int POOLS   = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           lk_vld,
   input  logic [ADDR_W-1:0]              lk_da,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] mac_i,
   input  logic [ENTRIES-1:0]             vld_i,
   input  logic [ENTRIES-1:0][POOLS-1:0]  pool_i,
   output logic                           res_vld,
   output logic                           res_hit,
   output logic [$clog2(ENTRIES)-1:0]     res_idx,
   output logic [POOLS-1:0]               res_pool
);
   localparam int IDX_W = $clog2(ENTRIES);

   logic [ENTRIES-1:0] hit_vec;
   logic               hit_any;
   logic [IDX_W-1:0]   win_idx;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = vld_i[e] && (mac_i[e] == lk_da);
   end

   assign hit_any = |hit_vec;

   always_comb begin
      win_idx = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (hit_vec[e]) win_idx = IDX_W'(e);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld  <= 1'b0;
         res_hit  <= 1'b0;
         res_idx  <= '0;
         res_pool <= '0;
      end else begin
         res_vld <= lk_vld;
         if (lk_vld && hit_any) begin
            res_hit  <= 1'b1;
            res_idx  <= win_idx;
            res_pool <= pool_i[win_idx];
         end else begin
            res_hit  <= 1'b0;
            res_idx  <= '0;
            res_pool <= '0;
         end
      end
   end

   p_res_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lk_vld |=> res_vld)
      else $error("lookup without result");
   p_res_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_vld |=> !res_vld)
      else $error("result without lookup");
   p_hit_in_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_vld)
      else $error("hit outside result cycle");
   p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !res_hit) |-> ((res_idx == '0) && (res_pool == '0)))
      else $error("miss carries data");

endmodule

// File: rtl/ucast_addr_filter.sv
module ucast_addr_filter
   import ucf_pkg::*;
#(
   parameter int                ENTRIES      = 32,
   parameter int                POOLS        = 32,
   parameter int                IDX_REG_W    = 8,
   parameter logic [ADDR_W-1:0] STATION_ADDR = 48'h02AB_CDEF_0001
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_wr,
   input  logic                       reg_rd,
   input  logic [2:0]                 reg_ofs,
   input  logic [3:0]                 reg_be,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic                       reg_rd_vld,
   input  logic                       lk_vld,
   input  logic [ADDR_W-1:0]          lk_da,
   output logic                       res_vld,
   output logic                       res_hit,
   output logic [$clog2(ENTRIES)-1:0] res_idx,
   output logic [POOLS-1:0]           res_pool
);
   initial begin
      a_entries_min: assert (ENTRIES >= 2) else $error("ENTRIES below 2");
      a_entries_fit: assert (ENTRIES <= (1 << IDX_REG_W)) else $error("selector too narrow");
      a_pools_rng:   assert (POOLS >= 2 && POOLS <= DATA_W) else $error("POOLS out of range");
   end

   ucf_ent_t [ENTRIES-1:0]             ent_v;
   logic [ENTRIES-1:0][POOLS-1:0]      pool_v;
   logic [ENTRIES-1:0][ADDR_W-1:0]     mac_v;
   logic [ENTRIES-1:0]                 vld_v;
   logic [ENTRIES-1:0]                 sel;
   logic                               idx_ok;
   logic                               wr_lo, wr_hi, pool_set, pool_clr;

   ucf_regif #(
      .ENTRIES(ENTRIES), .POOLS(POOLS), .IDX_REG_W(IDX_REG_W)
   ) regif_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs),
      .idx_wdata(reg_wdata[IDX_REG_W-1:0]),
      .reg_rdata(reg_rdata), .reg_rd_vld(reg_rd_vld),
      .ent_i(ent_v), .pool_i(pool_v),
      .sel_o(sel), .idx_ok_o(idx_ok),
      .wr_lo_o(wr_lo), .wr_hi_o(wr_hi),
      .pool_set_o(pool_set), .pool_clr_o(pool_clr)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      ucf_entry #(
         .IDX(e), .POOLS(POOLS),
         .RST_MAC((e == 0) ? STATION_ADDR : 48'h0),
         .RST_VLD(e == 0)
      ) entry_i (
         .clk(clk), .rst_n(rst_n), .sel(sel[e]),
         .wr_lo(wr_lo), .wr_hi(wr_hi),
         .pool_set(pool_set), .pool_clr(pool_clr),
         .be(reg_be), .wdata(reg_wdata),
         .ent_o(ent_v[e]), .pool_o(pool_v[e])
      );
      assign mac_v[e] = ent_v[e].mac;
      assign vld_v[e] = ent_v[e].valid;
   end

   ucf_match #(
      .ENTRIES(ENTRIES), .POOLS(POOLS)
   ) match_i (
      .clk(clk), .rst_n(rst_n),
      .lk_vld(lk_vld), .lk_da(lk_da),
      .mac_i(mac_v), .vld_i(vld_v), .pool_i(pool_v),
      .res_vld(res_vld), .res_hit(res_hit),
      .res_idx(res_idx), .res_pool(res_pool)
   );

   p_oob_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !idx_ok && (reg_ofs != REG_INDEX)) |=> ($stable(ent_v) && $stable(pool_v)))
      else $error("out-of-range write changed the table");

endmodule

// File: tb/ucast_addr_filter_tb.sv
module ucast_addr_filter_tb_top;
   localparam logic [47:0] STA = 48'h02AB_CDEF_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_ofs = '0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        reg_rd_vld;
   logic        lk_vld = 1'b0;
   logic [47:0] lk_da = '0;
   logic        res_vld, res_hit;
   logic [4:0]  res_idx;
   logic [31:0] res_pool;

   int checks = 0;
   int errors = 0;

   // bench table model
   logic [47:0] m_mac [32];
   logic [14:0] m_tag [32];
   logic        m_vld [32];
   logic [31:0] m_pool[32];
   logic [7:0]  m_idx;

   logic [37:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   ucast_addr_filter #(.STATION_ADDR(STA)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_ofs(reg_ofs), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rd_vld(reg_rd_vld),
      .lk_vld(lk_vld), .lk_da(lk_da),
      .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_pool(res_pool)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 32; i++) begin
         m_mac[i] = '0; m_tag[i] = '0; m_vld[i] = 1'b0; m_pool[i] = '0;
      end
      m_mac[0] = STA; m_vld[0] = 1'b1; m_idx = '0;
   endtask

   task automatic wr(input logic [2:0] ofs, input logic [3:0] be, input logic [31:0] d);
      int i;
      @(negedge clk);
      reg_wr = 1'b1; reg_ofs = ofs; reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
      i = int'(m_idx);
      if (ofs == 3'd0) m_idx = d[7:0];
      else if (i < 32) begin
         case (ofs)
            3'd1: for (int b = 0; b < 4; b++) if (be[b]) m_mac[i][8*b +: 8] = d[8*b +: 8];
            3'd2: begin
               if (be[0]) m_mac[i][39:32] = d[7:0];
               if (be[1]) m_mac[i][47:40] = d[15:8];
               if (be[2]) m_tag[i][7:0]   = d[23:16];
               if (be[3]) begin m_tag[i][14:8] = d[30:24]; m_vld[i] = d[31]; end
            end
            3'd3: m_pool[i] = m_pool[i] | (32'd1 << d[4:0]);
            3'd4: begin
               m_pool[i] = m_pool[i] & ~(32'd1 << d[4:0]);
               if (m_pool[i] == 0 && i != 0) begin m_mac[i] = '0; m_vld[i] = 1'b0; end
            end
            default: ;
         endcase
      end
   endtask

   task automatic rd_chk(input logic [2:0] ofs, input string req);
      logic [31:0] e;
      int i;
      i = int'(m_idx);
      e = '0;
      if (ofs == 3'd0) e = {24'd0, m_idx};
      else if (i < 32) begin
         case (ofs)
            3'd1: e = m_mac[i][31:0];
            3'd2: e = {m_vld[i], m_tag[i], m_mac[i][47:32]};
            3'd3, 3'd4: e = m_pool[i];
            default: e = '0;
         endcase
      end
      @(negedge clk);
      reg_rd = 1'b1; reg_ofs = ofs;
      @(negedge clk);
      reg_rd = 1'b0;
      check({req, " R10 rd_vld"}, {63'd0, reg_rd_vld}, 64'd1);
      check(req, {32'd0, reg_rdata}, {32'd0, e});
   endtask

   task automatic look(input logic [47:0] da, input string req);
      logic [37:0] e;
      e = '0;
      for (int i = 31; i >= 0; i--)
         if (m_vld[i] && m_mac[i] == da) e = {1'b1, 5'(i), m_pool[i]};
      exp_q.push_back(e);
      tag_q.push_back(req);
      @(negedge clk);
      lk_vld = 1'b1; lk_da = da;
      @(negedge clk);
      lk_vld = 1'b0;
   endtask

   task automatic put_addr(input logic [7:0] idx, input logic [47:0] a,
                           input logic vld, input logic [14:0] tg);
      wr(3'd0, 4'hF, {24'd0, idx});
      wr(3'd1, 4'hF, a[31:0]);
      wr(3'd2, 4'hF, {vld, tg, a[47:32]});
   endtask

   // monitor: pops the scoreboard on every result
   always @(negedge clk) begin
      if (rst_n && res_vld) begin
         if (exp_q.size() == 0) begin
            check("R9 unexpected result", 64'd1, 64'd0);
         end else begin
            logic [37:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " R9 lookup"}, {26'd0, res_hit, res_idx, res_pool}, {26'd0, e});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R9 watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   localparam logic [47:0] A = 48'h0211_2233_4455;

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      check("R8 res_vld after reset", {63'd0, res_vld}, 64'd0);
      check("R8 rd_vld after reset", {63'd0, reg_rd_vld}, 64'd0);
      rd_chk(3'd0, "R8 selector");
      rd_chk(3'd1, "R8 R2 entry0 low");
      rd_chk(3'd2, "R8 R2 entry0 high");
      rd_chk(3'd3, "R8 entry0 pool");
      wr(3'd0, 4'hF, 32'd5);
      rd_chk(3'd1, "R8 entry5 low");
      rd_chk(3'd2, "R8 entry5 high");
      look(STA, "R8 station hit");
      // R1 R2 program entry 3
      put_addr(8'd3, A, 1'b1, 15'h0);
      rd_chk(3'd0, "R1 selector");
      rd_chk(3'd1, "R2 low lanes");
      rd_chk(3'd2, "R2 high lanes");
      look(A, "R1 entry3 hit");
      look(A ^ 48'h1, "R3 one-bit miss");
      // R9 lowest index wins; R3 disabled entry skipped
      put_addr(8'd7, A, 1'b0, 15'h1234);
      look(A, "R3 disabled entry7");
      wr(3'd2, 4'h8, 32'h8000_0000);
      look(A, "R9 lowest of 3 and 7");
      wr(3'd0, 4'hF, 32'd3);
      wr(3'd2, 4'h8, 32'h0000_0000);
      look(A, "R3 entry3 disabled");
      // R4 lane masking on entry 7
      wr(3'd0, 4'hF, 32'd7);
      wr(3'd2, 4'h3, 32'h0000_0322);
      rd_chk(3'd2, "R4 tag and enable kept");
      rd_chk(3'd1, "R4 low untouched");
      wr(3'd1, 4'h5, 32'hAAAA_AAAA);
      rd_chk(3'd1, "R4 low lanes 0 and 2");
      wr(3'd1, 4'hF, A[31:0]);
      wr(3'd2, 4'h3, {16'd0, A[47:32]});
      // R5 pools
      wr(3'd3, 4'h0, 32'd2);
      wr(3'd3, 4'h0, 32'd9);
      rd_chk(3'd3, "R5 pool set");
      wr(3'd4, 4'h0, 32'd2);
      rd_chk(3'd4, "R5 pool clear");
      look(A, "R5 pool in result");
      // R6 auto clear
      wr(3'd4, 4'h0, 32'd9);
      rd_chk(3'd1, "R6 low cleared");
      rd_chk(3'd2, "R6 high cleared tag kept");
      look(A, "R6 cleared entry misses");
      wr(3'd0, 4'hF, 32'd0);
      wr(3'd3, 4'h0, 32'd31);
      rd_chk(3'd3, "R5 pool bit 31");
      wr(3'd4, 4'h0, 32'd31);
      rd_chk(3'd2, "R6 entry0 kept");
      look(STA, "R6 entry0 still hits");
      // R7 out-of-range selector
      wr(3'd0, 4'hF, 32'd32);
      wr(3'd1, 4'hF, 32'hDEAD_BEEF);
      wr(3'd2, 4'hF, 32'hFFFF_FFFF);
      wr(3'd3, 4'h0, 32'd4);
      rd_chk(3'd0, "R7 selector 32");
      rd_chk(3'd1, "R7 low reads zero");
      rd_chk(3'd2, "R7 high reads zero");
      rd_chk(3'd3, "R7 pool reads zero");
      wr(3'd0, 4'hF, 32'd200);
      wr(3'd4, 4'h0, 32'd0);
      rd_chk(3'd1, "R7 selector 200");
      look(48'hFFFF_DEAD_BEEF, "R7 ignored write misses");
      wr(3'd0, 4'hF, 32'd0);
      rd_chk(3'd1, "R7 entry0 unchanged");
      // top entry and back-to-back lookups
      put_addr(8'd31, 48'h0A0B_0C0D_0E0F, 1'b1, 15'h7FFF);
      wr(3'd3, 4'h0, 32'd17);
      for (int k = 0; k < 6; k++) begin
         exp_q.push_back('0); tag_q.push_back("placeholder");
         void'(exp_q.pop_back()); void'(tag_q.pop_back());
      end
      fork
         begin
            look(48'h0A0B_0C0D_0E0F, "R9 entry31 hit");
            look(STA, "R9 back-to-back station");
            look(48'h0, "R3 zero address miss");
            look(48'h0A0B_0C0D_0E0E, "R9 near miss");
         end
      join
      repeat (4) @(negedge clk);
      check("R9 all results seen", {32'd0, 32'(exp_q.size())}, 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule